// File: doc/BRIEF.md
# Rewindable Frame Byte Buffer

This block sits between a byte-stream source and a half-duplex transmit engine. It stores the opening bytes of the frame being sent, so the engine can start that frame again from its first byte after an early collision. Both sides use a valid/ready handshake, and each beat carries an end-of-frame marker. Each stored word holds a data byte and the error flag that goes with it. The block does not look inside the word.

The engine sends a one-cycle `rewind` pulse to move the read side back to the first byte of the current frame. This can happen any number of times. When the engine will not restart the frame again, it sends a one-cycle `commit` pulse. This happens when the frame has passed the collision window, when the engine gives up after the retry limit, or when it sees underflow early in the frame. After the commit, the stored bytes are freed and the rest of the frame flows through the ring in order.

The engine can abort a frame and drain it by holding `out_ready` high. The buffer keeps delivering source bytes until the beat marked last. When that beat has been delivered after a commit, the next frame's first byte becomes the new rewind point.

Top module: `stream_replay_buf`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: Every accepted word (`DATA_W` bits, passed through unchanged) comes out in order, together with its last marker.
- R3: When `DEPTH` words of an uncommitted frame are held, `in_ready` is 0, and it stays 0 while the consumer reads but does not commit. No held word is overwritten.
- R4: A `rewind` pulse makes the next output word the first word of the current frame. This can be repeated.
- R5: A frame shorter than `DEPTH` can still be rewound after its last word has been read, as long as no commit has been given.
- R6: After `commit`, every word the consumer reads frees its slot. `in_ready` returns, and the rest of a frame longer than `DEPTH` streams through with its last marker.
- R7: After a commit in mid-frame, the remaining words are delivered through the last one. The next frame's first word is then the rewind point.
- R8: `out_valid` is 0 whenever no unread word is present, including in the middle of a frame.
- R9: A `commit` given after a `rewind` commits from the frame's first word. The next output is that word, and no slot is freed until a word is read. `rewind` and `commit` are never high together.
- R10: While `out_valid` is 1 and `out_ready` is 0, the output word and marker stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_data | input | DATA_W | Source word (byte plus error flag) |
| in_last | input | 1 | Source end-of-frame marker |
| in_valid | input | 1 | Source word present |
| in_ready | output | 1 | Buffer can accept a word |
| out_data | output | DATA_W | Word to the transmit engine |
| out_last | output | 1 | End-of-frame marker of the output word |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Engine takes the output word |
| rewind | input | 1 | One-cycle pulse: restart the current frame |
| commit | input | 1 | One-cycle pulse: no further restart of this frame |

## Verification
The bench fills the ring with a frame longer than `DEPTH`, reads part of it, and checks that input stays blocked. A design that freed slots before the commit would overwrite the frame's first bytes, and a later rewind would return the wrong word. It rewinds a short frame after its last byte has been read, and drains a committed frame before rewinding into the next frame. A design that moved the rewind point at the wrong moment would replay stale data or skip words. It also rewinds and then commits, checks that the first word still comes out, and checks that `out_valid` drops on a mid-frame gap rather than showing an old word.

// File: rtl/rpl_pkg.sv
package rpl_pkg;
    // Where the current frame stands with respect to rewinding
    typedef enum logic [1:0] {
        PH_HOLD  = 2'd0,  // frame start pinned, rewind allowed
        PH_ENDED = 2'd1,  // last word read, still rewindable
        PH_PASS  = 2'd2   // committed, slots freed as words are read
    } phase_t;
endpackage

// File: rtl/rpl_step.sv
module rpl_step #(
    parameter int DEPTH = 57,
    parameter int AW    = 6
) (
    input  logic [AW-1:0] cur,
    output logic [AW-1:0] nxt
);
    always_comb begin
        if (cur == AW'(DEPTH - 1)) nxt = '0;
        else                       nxt = cur + AW'(1);
    end
endmodule

// File: rtl/rpl_store.sv
module rpl_store #(
    parameter int W     = 10,
    parameter int DEPTH = 57,
    parameter int AW    = 6
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/stream_replay_buf.sv
module stream_replay_buf #(
    parameter int DATA_W = 9,
    parameter int DEPTH  = 57
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_last,
    input  logic              in_valid,
    output logic              in_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_last,
    output logic              out_valid,
    input  logic              out_ready,
    input  logic              rewind,
    input  logic              commit
);
    import rpl_pkg::*;

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam int EW = DATA_W + 1;

    typedef struct packed {
        logic [AW-1:0] head;   // first word still held (rewind point)
        logic [AW-1:0] rd;     // next word to deliver
        logic [AW-1:0] wr;     // next free slot
        logic [CW-1:0] held;   // words from head to wr
        logic [CW-1:0] pend;   // words from rd to wr
        phase_t        ph;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [AW-1:0] rd_inc, wr_inc;
    logic [EW-1:0] rd_word;
    logic          push, pop, pop_last, release_now;

    rpl_step #(.DEPTH(DEPTH), .AW(AW)) u_rd_step (.cur(ctl_q.rd), .nxt(rd_inc));
    rpl_step #(.DEPTH(DEPTH), .AW(AW)) u_wr_step (.cur(ctl_q.wr), .nxt(wr_inc));

    rpl_store #(.W(EW), .DEPTH(DEPTH), .AW(AW)) u_store (
        .clk   (clk),
        .we    (push),
        .waddr (ctl_q.wr),
        .wdata ({in_last, in_data}),
        .raddr (ctl_q.rd),
        .rdata (rd_word)
    );

    assign in_ready  = (ctl_q.held != CW'(DEPTH));
    assign out_valid = (ctl_q.pend != '0);
    assign out_data  = rd_word[DATA_W-1:0];
    assign out_last  = rd_word[DATA_W];

    assign push     = in_valid && in_ready;
    assign pop      = out_valid && out_ready && !rewind;
    assign pop_last = pop && out_last;

    always_comb begin
        ctl_d       = ctl_q;
        release_now = commit || (ctl_q.ph == PH_PASS);

        if (push) ctl_d.wr = wr_inc;

        if (rewind) begin
            ctl_d.rd   = ctl_q.head;
            ctl_d.pend = ctl_q.held + CW'(push);
        end else begin
            if (pop) ctl_d.rd = rd_inc;
            ctl_d.pend = ctl_q.pend - CW'(pop) + CW'(push);
        end

        unique case (ctl_q.ph)
            PH_HOLD: begin
                if (commit)        ctl_d.ph = pop_last ? PH_HOLD : PH_PASS;
                else if (pop_last) ctl_d.ph = PH_ENDED;
            end
            PH_ENDED: begin
                if (rewind || commit) ctl_d.ph = PH_HOLD;
            end
            PH_PASS: begin
                if (pop_last) ctl_d.ph = PH_HOLD;
            end
            default: ctl_d.ph = PH_HOLD;
        endcase

        if (release_now) begin
            ctl_d.head = ctl_d.rd;
            ctl_d.held = ctl_d.pend;
        end else begin
            ctl_d.held = ctl_q.held + CW'(push);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{head: '0, rd: '0, wr: '0, held: '0, pend: '0, ph: PH_HOLD};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    // R3: counters stay inside the ring
    p_held_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.held <= CW'(DEPTH)) && (ctl_q.pend <= ctl_q.held));

    // R3: a full, uncommitted ring stays blocked
    p_full_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_ready && ctl_q.ph != PH_PASS && !commit) |=> !in_ready);

    // R4: rewinding a non-empty frame presents a word
    p_rewind_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rewind && ctl_q.held != '0) |=> out_valid);

    // R6: after a commit nothing remains held behind the read point
    p_commit_frees_r6: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (ctl_q.held == ctl_q.pend));

    // R8: an empty ring with no input and no rewind stays invalid
    p_empty_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_valid && !in_valid && !rewind) |=> !out_valid);

    // R9: pulses are exclusive
    p_pulse_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(rewind && commit));

    // R10: stalled output holds
    p_stall_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !rewind) |=>
            (out_valid && $stable(out_data) && $stable(out_last)));
endmodule

// File: tb/sim_stream_replay_buf.sv
module sim_stream_replay_buf;
    localparam int DATA_W = 9;
    localparam int DEPTH  = 57;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [DATA_W-1:0] in_data = '0;
    logic              in_last = 1'b0;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [DATA_W-1:0] out_data;
    logic              out_last;
    logic              out_valid;
    logic              out_ready = 1'b0;
    logic              rewind = 1'b0;
    logic              commit = 1'b0;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    always #2 clk = ~clk;

    stream_replay_buf #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n),
        .in_data(in_data), .in_last(in_last), .in_valid(in_valid), .in_ready(in_ready),
        .out_data(out_data), .out_last(out_last), .out_valid(out_valid), .out_ready(out_ready),
        .rewind(rewind), .commit(commit)
    );

    function automatic logic [DATA_W-1:0] word(input int base, input int i);
        logic [7:0] b;
        b = 8'(base + i);
        return {b, 1'((i % 7) == 3)};
    endfunction

    task automatic chk(input int act, input int exp, input string req);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push(input logic [DATA_W-1:0] d, input logic l);
        @(negedge clk);
        in_valid = 1'b1; in_data = d; in_last = l;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic pop_expect(input logic [DATA_W-1:0] d, input logic l, input string req);
        @(negedge clk);
        chk(int'(out_valid), 1, req);
        chk(int'(out_data), int'(d), req);
        chk(int'(out_last), int'(l), req);
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    task automatic pulse_rewind();
        @(negedge clk); rewind = 1'b1;
        @(negedge clk); rewind = 1'b0;
    endtask

    task automatic pulse_commit();
        @(negedge clk); commit = 1'b1;
        @(negedge clk); commit = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(int'(out_valid), 0, "R1 out_valid");
        chk(int'(in_ready), 1, "R1 in_ready");
    endtask

    task automatic t_short();
        for (int i = 0; i < 5; i++) push(word(8'h10, i), i == 4);
        for (int i = 0; i < 5; i++) pop_expect(word(8'h10, i), i == 4, "R2 in-order");
        @(negedge clk);
        chk(int'(out_valid), 0, "R8 empty after frame");
        pulse_rewind();
        pop_expect(word(8'h10, 0), 1'b0, "R5 replay after last");
        pulse_rewind();
        for (int i = 0; i < 5; i++) pop_expect(word(8'h10, i), i == 4, "R4 repeated rewind");
        pulse_commit();
        for (int i = 0; i < 3; i++) push(word(8'h30, i), i == 2);
        pop_expect(word(8'h30, 0), 1'b0, "R7 next frame");
        pulse_rewind();
        for (int i = 0; i < 3; i++) pop_expect(word(8'h30, i), i == 2, "R7 new rewind point");
        pulse_commit();
    endtask

    task automatic t_full();
        for (int i = 0; i < DEPTH; i++) push(word(0, i), 1'b0);
        chk(int'(in_ready), 0, "R3 full blocks");
        for (int i = 0; i < 10; i++) pop_expect(word(0, i), 1'b0, "R2 long frame");
        @(negedge clk);
        chk(int'(in_ready), 0, "R3 reads do not free");
        pulse_rewind();
        pop_expect(word(0, 0), 1'b0, "R4 rewind to start");
        pop_expect(word(0, 1), 1'b0, "R4 second word");
        pulse_rewind();
        pulse_commit();
        @(negedge clk);
        chk(int'(in_ready), 0, "R9 commit frees nothing yet");
        pop_expect(word(0, 0), 1'b0, "R9 first word after commit");
        @(negedge clk);
        chk(int'(in_ready), 1, "R6 slot freed");
        push(word(0, DEPTH), 1'b0);
        for (int i = 1; i < 70; i++) begin
            pop_expect(word(0, i), i == 69, "R6 pass-through");
            if (i + DEPTH < 70) push(word(0, i + DEPTH), (i + DEPTH) == 69);
        end
        @(negedge clk);
        chk(int'(out_valid), 0, "R8 drained");
    endtask

    task automatic t_drain();
        for (int i = 0; i < 10; i++) push(word(8'h40, i), i == 9);
        for (int i = 0; i < 3; i++) pop_expect(word(8'h40, i), 1'b0, "R2 pre-abort");
        pulse_commit();
        for (int i = 3; i < 10; i++) pop_expect(word(8'h40, i), i == 9, "R7 drain");
        for (int i = 0; i < 2; i++) push(word(8'h80, i), i == 1);
        pop_expect(word(8'h80, 0), 1'b0, "R7 next first");
        pulse_rewind();
        pop_expect(word(8'h80, 0), 1'b0, "R7 rewind to next start");
        pop_expect(word(8'h80, 1), 1'b1, "R7 next last");
        pulse_commit();
    endtask

    task automatic t_stall();
        push(word(8'hA0, 0), 1'b0);
        push(word(8'hA0, 1), 1'b1);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(int'(out_data), int'(word(8'hA0, 0)), "R10 stall data");
            chk(int'(out_last), 0, "R10 stall last");
        end
        pop_expect(word(8'hA0, 0), 1'b0, "R10 after stall");
        pop_expect(word(8'hA0, 1), 1'b1, "R10 after stall");
        pulse_commit();
    endtask

    task automatic t_gap();
        push(word(8'hC0, 0), 1'b0);
        pop_expect(word(8'hC0, 0), 1'b0, "R8 gap first");
        @(negedge clk);
        chk(int'(out_valid), 0, "R8 mid-frame underflow");
        push(word(8'hC0, 1), 1'b1);
        pop_expect(word(8'hC0, 1), 1'b1, "R8 resumes");
        pulse_commit();
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                total++; bad++;
                $display("FAIL watchdog: actual=%0d expected<=100000", cyc);
                $display("  test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_short();
        t_full();
        t_drain();
        t_stall();
        t_gap();
        repeat (2) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule